// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory instruction into the stream of element addresses that a load/store unit sends to memory. On a start strobe it captures a scalar base address, a signed stride, an index vector, an addressing mode, a vector length and a load/store flag. It then emits one element number and byte address per cycle on a valid/ready channel, and pulses `done` once the sequence is finished.

Three addressing modes are supported. Unit-stride walks contiguous 4-byte words from the base. Strided mode steps by a signed element stride that is scaled to bytes. Indexed mode (gather for loads, scatter for stores) adds each signed index entry, scaled to bytes, to the base. Element numbers always count up from zero, so the data lands densely in the register whatever the memory spacing is.

The controller is a three-state machine. IDLE waits for `start`. IDLE→RUN happens on a start with a non-zero length, and IDLE→FINISH on a start with zero length. RUN holds while the current address is not accepted or is not the last one. RUN→FINISH happens when the last address is accepted. FINISH→IDLE is unconditional after one cycle.

Top module: `vec_agu`

## Requirements
- R1: Mode 0 (unit stride, and mode 3 behaves the same) emits address base + 4·i for element i.
- R2: Mode 1 (strided) emits base + 4·stride·i modulo 2^32, with the stride a signed 32-bit element count. A zero stride repeats the base on every element.
- R3: Mode 2 (indexed) emits base + 4·sext(idx[i]) for element i. Entry i sits at bits [i·16 +: 16] of `idx_vec` and is a signed 16-bit element offset.
- R4: Exactly `vl` addresses are emitted, with `out_elem` running 0,1,…,vl−1 in order and one address per cycle while `out_ready` is high.
- R5: While `out_valid` is high and `out_ready` is low, `out_addr`, `out_elem` and `out_store` hold their values, and no element is skipped.
- R6: `done` is high for exactly one cycle, in the cycle after the last address is accepted.
- R7: A start with `vl` = 0 emits no address and raises `done` in the cycle after the start.
- R8: `out_store` equals the `is_store` value captured at start, for every element of the sequence.
- R9: A `start` while `busy` is high has no effect on the running sequence.
- R10: After reset, `busy`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new sequence (taken only when idle) |
| mode | input | 2 | 0 unit, 1 strided, 2 indexed, 3 unit |
| is_store | input | 1 | Load (0) or store (1) flag |
| base | input | 32 | Scalar base byte address |
| stride | input | 32 | Signed stride in elements |
| idx_vec | input | 128 | Eight signed 16-bit index entries |
| vl | input | 4 | Vector length, 0 to 8 |
| busy | output | 1 | Sequence in progress |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Consumer accepts address |
| out_elem | output | 3 | Element number of the address |
| out_addr | output | 32 | Element byte address |
| out_store | output | 1 | Captured load/store flag |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two events can meet in one clock: acceptance of the final address, which must move the machine to FINISH, and a new `start`, which must be ignored because the block is still busy. The bench raises `start` with different operands while a sequence is running and its consumer is stalling, and again on the cycle the last handshake completes. A behavioural queue model, compared on every cycle, then requires `done` one cycle later and the old addresses unchanged.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [1:0] {
        AM_UNIT    = 2'd0,
        AM_STRIDED = 2'd1,
        AM_INDEXED = 2'd2,
        AM_UNIT_B  = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/agu_idx_pick.sv
module agu_idx_pick #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 16,
    parameter int MAX_VL    = 8,
    parameter int SCALE_LOG = 2,
    localparam int EL_W     = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic [MAX_VL*IDX_W-1:0] idx_flat,
    input  logic [EL_W-1:0]         sel,
    output logic [ADDR_W-1:0]       byte_off
);
    logic [ADDR_W-1:0] ext_off [MAX_VL];

    for (genvar g = 0; g < MAX_VL; g++) begin : g_entry
        logic [IDX_W-1:0] raw;
        assign raw        = idx_flat[g*IDX_W +: IDX_W];
        assign ext_off[g] = {{(ADDR_W-IDX_W){raw[IDX_W-1]}}, raw} << SCALE_LOG;
    end

    assign byte_off = ext_off[sel];
endmodule

// File: rtl/agu_addr_mux.sv
module agu_addr_mux
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  addr_mode_e        mode,
    input  logic [ADDR_W-1:0] run_addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] idx_off,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        unique case (mode)
            AM_INDEXED: addr = base + idx_off;
            default:    addr = run_addr;
        endcase
    end
endmodule

// File: rtl/vec_agu.sv
module vec_agu
    import agu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 16,
    parameter int MAX_VL    = 8,
    parameter int SCALE_LOG = 2,
    localparam int EL_W     = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
    localparam int VL_W     = $clog2(MAX_VL + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              mode,
    input  logic                    is_store,
    input  logic [ADDR_W-1:0]       base,
    input  logic [ADDR_W-1:0]       stride,
    input  logic [MAX_VL*IDX_W-1:0] idx_vec,
    input  logic [VL_W-1:0]         vl,
    output logic                    busy,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [EL_W-1:0]         out_elem,
    output logic [ADDR_W-1:0]       out_addr,
    output logic                    out_store,
    output logic                    done
);
    seq_state_e              state_q, state_d;
    addr_mode_e              mode_q;
    logic [EL_W-1:0]         elem_q;
    logic [VL_W-1:0]         vl_q;
    logic [ADDR_W-1:0]       base_q, step_q, acc_q;
    logic [MAX_VL*IDX_W-1:0] idx_q;
    logic                    store_q;
    logic                    take, fire, last;
    logic [ADDR_W-1:0]       idx_off;

    assign take = (state_q == ST_IDLE) && start;
    assign fire = (state_q == ST_RUN) && out_ready;
    assign last = (VL_W'(elem_q) == vl_q - VL_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (vl == '0) ? ST_FINISH : ST_RUN;
            end
            ST_RUN: begin
                if (out_ready && last) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and sequencing datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= AM_UNIT;
            elem_q  <= '0;
            vl_q    <= '0;
            base_q  <= '0;
            step_q  <= '0;
            acc_q   <= '0;
            idx_q   <= '0;
            store_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                mode_q  <= addr_mode_e'(mode);
                elem_q  <= '0;
                vl_q    <= vl;
                base_q  <= base;
                acc_q   <= base;
                idx_q   <= idx_vec;
                store_q <= is_store;
                step_q  <= (addr_mode_e'(mode) == AM_STRIDED) ? (stride << SCALE_LOG)
                                                              : ADDR_W'(1 << SCALE_LOG);
            end else if (fire && !last) begin
                elem_q <= elem_q + EL_W'(1);
                acc_q  <= acc_q + step_q;
            end
        end
    end

    agu_idx_pick #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .MAX_VL(MAX_VL), .SCALE_LOG(SCALE_LOG)
    ) u_pick (
        .idx_flat(idx_q),
        .sel     (elem_q),
        .byte_off(idx_off)
    );

    agu_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
        .mode    (mode_q),
        .run_addr(acc_q),
        .base    (base_q),
        .idx_off (idx_off),
        .addr    (out_addr)
    );

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        out_valid = (state_q == ST_RUN);
        done      = (state_q == ST_FINISH);
        out_elem  = elem_q;
        out_store = store_q;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_elem)
                                    && $stable(out_store)); // R5
    AST_ELEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !done && (VL_W'(out_elem) + VL_W'(1) < vl_q)
        |=> out_valid && (out_elem == $past(out_elem) + EL_W'(1))); // R4
    AST_ELEM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (VL_W'(out_elem) < vl_q)); // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && (VL_W'(out_elem) + VL_W'(1) == vl_q) |=> done); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !out_valid); // R6
    AST_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && done)); // R6
endmodule

// File: tb/vec_agu_bench.sv
module vec_agu_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         is_store = 1'b0;
    logic [31:0]  base = '0;
    logic [31:0]  stride = '0;
    logic [127:0] idx_vec = '0;
    logic [3:0]   vl = '0;
    logic         out_ready = 1'b1;
    logic         busy, out_valid, out_store, done;
    logic [2:0]   out_elem;
    logic [31:0]  out_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string req = "R10";

    // behavioural model
    int          m_state = 0;   // 0 idle, 1 run, 2 finish
    logic [31:0] q_addr[$];
    int          q_elem[$];
    logic        m_store = 1'b0;

    always #5 clk = ~clk;

    vec_agu u_vec_agu (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_store(is_store),
        .base(base), .stride(stride), .idx_vec(idx_vec), .vl(vl), .busy(busy),
        .out_valid(out_valid), .out_ready(out_ready), .out_elem(out_elem),
        .out_addr(out_addr), .out_store(out_store), .done(done)
    );

    function automatic logic [31:0] ref_addr(int i);
        logic [15:0] e;
        e = idx_vec[i*16 +: 16];
        if (mode == 2'd2) return base + ({{16{e[15]}}, e} << 2);
        if (mode == 2'd1) return base + (32'(i) * stride) * 32'd4;
        return base + 32'(i) * 32'd4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
            q_addr.delete();
            q_elem.delete();
        end else begin
            case (m_state)
                0: if (start) begin
                    m_store = is_store;
                    for (int i = 0; i < int'(vl); i++) begin
                        q_addr.push_back(ref_addr(i));
                        q_elem.push_back(i);
                    end
                    m_state = (vl == 0) ? 2 : 1;
                end
                1: if (out_ready) begin
                    void'(q_addr.pop_front());
                    void'(q_elem.pop_front());
                    if (q_addr.size() == 0) m_state = 2;
                end
                default: m_state = 0;
            endcase
        end
    end

    task automatic check(bit ok, string what, string act, string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %s expected %s", req, what, act, exp);
        end
    endtask

    task automatic compare();
        check(out_valid == (m_state == 1), "valid", $sformatf("%0b", out_valid),
              $sformatf("%0b", m_state == 1));
        check(done == (m_state == 2), "done", $sformatf("%0b", done),
              $sformatf("%0b", m_state == 2));
        check(busy == (m_state != 0), "busy", $sformatf("%0b", busy),
              $sformatf("%0b", m_state != 0));
        if (m_state == 1 && q_addr.size() > 0) begin
            check(out_addr == q_addr[0], "addr", $sformatf("%h", out_addr),
                  $sformatf("%h", q_addr[0]));
            check(int'(out_elem) == q_elem[0], "elem", $sformatf("%0d", out_elem),
                  $sformatf("%0d", q_elem[0]));
            check(out_store == m_store, "store R8", $sformatf("%0b", out_store),
                  $sformatf("%0b", m_store));
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic launch(logic [1:0] md, logic st, logic [31:0] b, logic [31:0] s, int n);
        step();
        mode = md; is_store = st; base = b; stride = s; vl = 4'(n); start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic drain(bit toggle);
        int k = 0;
        while (m_state != 0 && k < 100) begin
            if (toggle) out_ready = (k % 3) != 1;
            step();
            k++;
        end
        out_ready = 1'b1;
        step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL R4 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        req = "R10";
        check(!busy && !out_valid && !done, "reset", $sformatf("%0b%0b%0b", busy, out_valid, done), "000");
        rst_n = 1'b1;

        req = "R1 R4";
        launch(2'd0, 1'b0, 32'h0000_1000, 32'd0, 5);
        drain(0);

        req = "R1 mode3";
        launch(2'd3, 1'b1, 32'h0000_2000, 32'd9, 3);
        drain(0);

        req = "R2 R5";
        launch(2'd1, 1'b0, 32'h0001_0000, 32'd3, 8);
        drain(1);

        req = "R2 negative";
        launch(2'd1, 1'b1, 32'h0000_0010, 32'hFFFF_FFFE, 4);
        drain(0);

        req = "R2 zero";
        launch(2'd1, 1'b0, 32'h0000_0400, 32'd0, 3);
        drain(0);

        req = "R3 R8";
        idx_vec = {16'd7, 16'hFFFF, 16'd0, 16'h8000, 16'h7FFF, 16'd2, 16'hFFFC, 16'd5};
        launch(2'd2, 1'b1, 32'h0000_8000, 32'd0, 6);
        drain(0);

        req = "R7";
        launch(2'd0, 1'b0, 32'h0000_3000, 32'd0, 0);
        drain(0);

        req = "R9 R5";
        launch(2'd2, 1'b0, 32'h0000_4000, 32'd0, 8);
        out_ready = 1'b0;
        step(); step();
        mode = 2'd0; base = 32'hDEAD_0000; vl = 4'd2; start = 1'b1; is_store = 1'b1;
        step(); step();
        start = 1'b0; out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        step(); step();
        out_ready = 1'b1;
        while (m_state == 1 && q_addr.size() > 1) step();
        start = 1'b1;
        step();
        start = 1'b0;
        req = "R6 R9";
        drain(0);
        req = "R6";
        check(!done && !busy, "idle after done", $sformatf("%0b%0b", done, busy), "00");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule